// File: doc/BRIEF.md
# Half-Bridge Command Conditioner

This block conditions the two switch commands of one half-bridge leg before they reach the gate drivers. One instance serves one phase; a three-phase controller places three of them side by side. The high-side and low-side commands arrive active low and asynchronous to the clock. Each one is synchronised, cleaned of short noise pulses by a run-length filter, and then turned into active-high drive enables.

A control stage sits between the filtered requests and the enables. In complementary mode it blocks shoot-through: a request for both switches at once turns both off, and every turn-on waits for a programmable dead interval after the most recent turn-off of either output. In independent mode the enables follow the filtered requests directly, so both switches may conduct together. A global inhibit, for a fault or undervoltage, clears both enables. A high-side inhibit clears only the upper enable.

The filter length `FILT_CYC` and the dead interval `DEAD_CYC` are parameters in clock cycles. The defaults suit a 100 MHz clock: 400 ns of filtering and 1.2 µs of deadtime.

Top module: `hb_gate_cond`

## Requirements
- R1: A low level on `hiCmdN` or `loCmdN` requests the matching enable (`hiDrive` or `loDrive`) high. A high level requests it low.
- R2: While `rstN` is low both enables are low. The input path restarts at the released (high) level, so an input already held low during reset turns its enable on only after the full latency of R4, counted from the release.
- R3: A change of a command input must hold for `FILT_CYC` consecutive sampled cycles to take effect. A pulse of `FILT_CYC-1` cycles leaves the enable unchanged.
- R4: A command change that is accepted appears on the enable exactly `FILT_CYC+3` clock edges after it is applied. These edges are two synchroniser stages, `FILT_CYC` filter samples and one output register.
- R5: In complementary mode (`indepMode` = 0) an enable may rise only when the other enable is low and at least `DEAD_CYC` cycles have passed since any enable last fell. A handover therefore keeps both enables low for exactly `DEAD_CYC` cycles. The rule also applies when one output turns back on after its own turn-off.
- R6: In complementary mode, when both filtered requests are active, both enables go low and the two are never high together.
- R7: In independent mode (`indepMode` = 1) each enable follows its own filtered request with no deadtime, so requests (on, on) give enables (1, 1) on the next edge.
- R8: `inhibitAll` high forces both enables low on the next clock edge, whatever the requests are.
- R9: `inhibitHigh` high forces `hiDrive` low on the next clock edge and leaves `loDrive` unaffected.
- R10: `indepMode`, `inhibitAll` and `inhibitHigh` are not filtered. A change on any of them acts on the next clock edge. When an inhibit is released, the enables come back under the R5 and R7 rules.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hiCmdN | input | 1 | High-side command, active low, asynchronous |
| loCmdN | input | 1 | Low-side command, active low, asynchronous |
| indepMode | input | 1 | 1 = independent mode, 0 = complementary mode |
| inhibitAll | input | 1 | Global inhibit, clears both enables |
| inhibitHigh | input | 1 | High-side inhibit, clears only the upper enable |
| hiDrive | output | 1 | High-side drive enable, active high |
| loDrive | output | 1 | Low-side drive enable, active high |

## Verification
The internal state is the filtered level, the filter run counter and the shared dead counter, and none of it can be seen directly. A wrong filter count shows up as an enable edge one or more cycles away from the `FILT_CYC+3` mark, or as a glitch that gets through. A dead counter that is loaded with the wrong value, or that misses a turn-off, shows up on the first turn-on after it: the output rises before or after the `DEAD_CYC` boundary, within one dead interval. The bench therefore samples one cycle before and one cycle at each predicted edge, so an error of one cycle in either direction is caught. Errors in the mode and inhibit paths show up one edge after the control input changes.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

  // control -> datapath strobes
  typedef struct packed {
    logic dtLoad;   // an enable is falling this cycle: restart the dead interval
  } ctrl_strobe_t;

  // datapath -> control status
  typedef struct packed {
    logic reqHi;    // filtered high-side request, active high
    logic reqLo;    // filtered low-side request, active high
    logic dtDone;   // dead interval has elapsed
  } path_status_t;

endpackage

// File: rtl/hbc_filter.sv
module hbc_filter #(
  parameter int FILT_CYC   = 40,
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawN,
  output logic levelN
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [SYNC_DEPTH-1:0] syncReg;
  logic [CW-1:0]         runCnt;
  logic                  sampled;

  assign sampled = syncReg[SYNC_DEPTH-1];

  // synchroniser starts at the released level so a floating input reads as off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= '1;
    else       syncReg <= {syncReg[SYNC_DEPTH-2:0], rawN};
  end

  // the accepted level moves only after FILT_CYC consecutive differing samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelN <= 1'b1;
      runCnt <= '0;
    end else if (sampled == levelN) begin
      runCnt <= '0;
    end else if (runCnt == CW'(FILT_CYC - 1)) begin
      levelN <= sampled;
      runCnt <= '0;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end
endmodule

// File: rtl/hbc_datapath.sv
module hbc_datapath
  import hbc_pkg::*;
#(
  parameter int FILT_CYC = 40,
  parameter int DEAD_CYC = 120
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hiCmdN,
  input  logic         loCmdN,
  input  ctrl_strobe_t strobe,
  output path_status_t status
);
  localparam int LANES = 2;   // lane 1 = high side, lane 0 = low side
  localparam int DW    = $clog2(DEAD_CYC + 1);

  logic [LANES-1:0] rawN;
  logic [LANES-1:0] levelN;
  logic [DW-1:0]    deadCnt;

  assign rawN = {hiCmdN, loCmdN};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    hbc_filter #(.FILT_CYC(FILT_CYC), .SYNC_DEPTH(2)) u_filt (
      .clk   (clk),
      .rstN  (rstN),
      .rawN  (rawN[g]),
      .levelN(levelN[g])
    );
  end

  // shared dead interval: loaded on any turn-off, counts down to zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                deadCnt <= '0;
    else if (strobe.dtLoad)   deadCnt <= DW'(DEAD_CYC - 1);
    else if (deadCnt != '0)   deadCnt <= deadCnt - 1'b1;
  end

  assign status.reqHi  = ~levelN[1];
  assign status.reqLo  = ~levelN[0];
  assign status.dtDone = (deadCnt == '0);
endmodule

// File: rtl/hbc_control.sv
module hbc_control
  import hbc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  path_status_t status,
  input  logic         indepMode,
  input  logic         inhibitAll,
  input  logic         inhibitHigh,
  output ctrl_strobe_t strobe,
  output logic         hiDrive,
  output logic         loDrive
);
  logic tgtHi, tgtLo;
  logic allowHi, allowLo;
  logic nextHi, nextLo;

  always_comb begin
    tgtHi = status.reqHi;
    tgtLo = status.reqLo;
    if (!indepMode && status.reqHi && status.reqLo) begin
      tgtHi = 1'b0;
      tgtLo = 1'b0;
    end
    if (inhibitHigh) tgtHi = 1'b0;
    if (inhibitAll) begin
      tgtHi = 1'b0;
      tgtLo = 1'b0;
    end
  end

  // a rising enable needs the opposite side off and the dead interval spent
  assign allowHi = indepMode | (status.dtDone & ~loDrive);
  assign allowLo = indepMode | (status.dtDone & ~hiDrive);
  assign nextHi  = tgtHi & (hiDrive | allowHi);
  assign nextLo  = tgtLo & (loDrive | allowLo);

  assign strobe.dtLoad = (hiDrive & ~nextHi) | (loDrive & ~nextLo);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiDrive <= 1'b0;
      loDrive <= 1'b0;
    end else begin
      hiDrive <= nextHi;
      loDrive <= nextLo;
    end
  end
endmodule

// File: rtl/hb_gate_cond.sv
module hb_gate_cond
  import hbc_pkg::*;
#(
  parameter int FILT_CYC = 40,
  parameter int DEAD_CYC = 120
) (
  input  logic clk,
  input  logic rstN,
  input  logic hiCmdN,
  input  logic loCmdN,
  input  logic indepMode,
  input  logic inhibitAll,
  input  logic inhibitHigh,
  output logic hiDrive,
  output logic loDrive
);
  ctrl_strobe_t strobe;
  path_status_t status;

  hbc_datapath #(.FILT_CYC(FILT_CYC), .DEAD_CYC(DEAD_CYC)) u_path (
    .clk   (clk),
    .rstN  (rstN),
    .hiCmdN(hiCmdN),
    .loCmdN(loCmdN),
    .strobe(strobe),
    .status(status)
  );

  hbc_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .status     (status),
    .indepMode  (indepMode),
    .inhibitAll (inhibitAll),
    .inhibitHigh(inhibitHigh),
    .strobe     (strobe),
    .hiDrive    (hiDrive),
    .loDrive    (loDrive)
  );
endmodule

// File: rtl/hbc_checker.sv
module hbc_checker #(
  parameter int DEAD_CYC = 120
) (
  input logic clk,
  input logic rstN,
  input logic indepMode,
  input logic inhibitAll,
  input logic inhibitHigh,
  input logic hiDrive,
  input logic loDrive
);
  localparam int GW = $clog2(DEAD_CYC + 1);

  logic          prevHi, prevLo, prevMode;
  logic [GW-1:0] gap;   // cycles since either enable last fell, saturating

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevHi   <= 1'b0;
      prevLo   <= 1'b0;
      prevMode <= 1'b0;
      gap      <= GW'(DEAD_CYC);
    end else begin
      prevHi   <= hiDrive;
      prevLo   <= loDrive;
      prevMode <= indepMode;
      if ((prevHi && !hiDrive) || (prevLo && !loDrive)) gap <= GW'(1);
      else if (gap < GW'(DEAD_CYC))                       gap <= gap + 1'b1;
    end
  end

  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rstN)
    !indepMode |=> !(hiDrive && loDrive));

  p_all_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    inhibitAll |=> (!hiDrive && !loDrive));

  p_high_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    inhibitHigh |=> !hiDrive);

  p_hi_dead_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hiDrive && !prevHi && !prevMode) |-> (gap >= GW'(DEAD_CYC)));

  p_lo_dead_r5: assert property (@(posedge clk) disable iff (!rstN)
    (loDrive && !prevLo && !prevMode) |-> (gap >= GW'(DEAD_CYC)));

  p_hi_rise_other_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hiDrive && !prevHi && !prevMode) |-> !prevLo);
endmodule

bind hb_gate_cond hbc_checker #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .indepMode  (indepMode),
  .inhibitAll (inhibitAll),
  .inhibitHigh(inhibitHigh),
  .hiDrive    (hiDrive),
  .loDrive    (loDrive)
);

// File: tb/hb_gate_cond_test.sv
module hb_gate_cond_test;
  localparam int F = 40;
  localparam int D = 120;
  localparam int L = F + 3;   // command-to-enable latency (R4)

  logic clk = 1'b0;
  logic rstN, hiCmdN, loCmdN, indepMode, inhibitAll, inhibitHigh;
  logic hiDrive, loDrive;

  typedef struct {
    int unsigned at;
    bit          hi;
    bit          lo;
    string       tag;
  } exp_item_t;

  exp_item_t   expQ[$];
  int unsigned cyc = 0;
  int          nChecks = 0;
  int          nBad = 0;
  bit          done = 1'b0;

  hb_gate_cond #(.FILT_CYC(F), .DEAD_CYC(D)) uut (
    .clk(clk), .rstN(rstN), .hiCmdN(hiCmdN), .loCmdN(loCmdN),
    .indepMode(indepMode), .inhibitAll(inhibitAll), .inhibitHigh(inhibitHigh),
    .hiDrive(hiDrive), .loDrive(loDrive)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expectAt(input int off, input bit h, input bit l, input string tag);
    exp_item_t it;
    it.at = cyc + off; it.hi = h; it.lo = l; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic checkNow(input bit h, input bit l, input string tag);
    nChecks++;
    if (hiDrive !== h || loDrive !== l) begin
      nBad++;
      $display("FAIL %s: cycle %0d hi/lo actual=%0b%0b expected=%0b%0b",
               tag, cyc, hiDrive, loDrive, h, l);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expectations that are due and compares them
  always @(negedge clk) begin
    for (int i = expQ.size() - 1; i >= 0; i--) begin
      if (expQ[i].at == cyc) begin
        checkNow(expQ[i].hi, expQ[i].lo, expQ[i].tag);
        expQ.delete(i);
      end
    end
  end

  // watchdog
  initial begin
    while (!done && cyc < 100000) @(negedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    int m;
    rstN = 1'b0; hiCmdN = 1'b1; loCmdN = 1'b0;
    indepMode = 1'b0; inhibitAll = 1'b0; inhibitHigh = 1'b0;
    waitN(3);
    checkNow(0, 0, "R2 outputs low in reset");

    // R2/R4: low-side request held through reset appears after full latency
    rstN = 1'b1;
    expectAt(L - 1, 0, 0, "R2 lo still off before latency");
    expectAt(L,     0, 1, "R1 R4 lo on after latency");
    waitN(L + 5);

    // R3: off pulse one cycle too short is rejected
    loCmdN = 1'b1;
    expectAt(L,         0, 1, "R3 short pulse rejected");
    expectAt(L + F,     0, 1, "R3 short pulse rejected later");
    waitN(F - 1);
    loCmdN = 1'b0;
    waitN(2 * L);

    // R3/R5: pulse of exactly F passes; return waits the dead interval
    loCmdN = 1'b1;
    expectAt(L - 1,     0, 1, "R3 full pulse not yet seen");
    expectAt(L,         0, 0, "R3 full pulse accepted");
    expectAt(L + D - 1, 0, 0, "R5 re-turn-on held by deadtime");
    expectAt(L + D,     0, 1, "R5 re-turn-on after deadtime");
    waitN(F);
    loCmdN = 1'b0;
    waitN(L + D + 5);

    // R1: release low side
    loCmdN = 1'b1;
    expectAt(L - 1, 0, 1, "R4 lo off latency early");
    expectAt(L,     0, 0, "R1 lo off");
    waitN(L + D + 5);

    // R1: high side on
    hiCmdN = 1'b0;
    expectAt(L - 1, 0, 0, "R4 hi on latency early");
    expectAt(L,     1, 0, "R1 hi on");
    waitN(L + 5);

    // R5: simultaneous handover high -> low
    hiCmdN = 1'b1; loCmdN = 1'b0;
    expectAt(L - 1,     1, 0, "R5 hi still on");
    expectAt(L,         0, 0, "R5 hi off first");
    expectAt(L + D - 1, 0, 0, "R5 dead interval");
    expectAt(L + D,     0, 1, "R5 lo on after deadtime");
    waitN(L + D + 5);

    // R6/R5: near-coincident handover low -> high with overlap of requests
    hiCmdN = 1'b0;
    expectAt(L - 1,     0, 1, "R6 lo on before overlap");
    expectAt(L,         0, 0, "R6 overlap forces both off");
    expectAt(L + 2,     0, 0, "R6 overlap both off");
    expectAt(L + D - 1, 0, 0, "R5 dead after overlap");
    expectAt(L + D,     1, 0, "R5 hi on after deadtime");
    waitN(5);
    loCmdN = 1'b1;
    waitN(L + D);

    hiCmdN = 1'b1;
    expectAt(L, 0, 0, "R1 hi off");
    waitN(L + D + 5);

    // R6: both requested together in complementary mode
    hiCmdN = 1'b0; loCmdN = 1'b0;
    expectAt(L + 2,     0, 0, "R6 both requested stay off");
    expectAt(L + D + 5, 0, 0, "R6 both requested stay off later");
    waitN(L + D + 10);

    // R7/R10: independent mode allows both on next edge
    indepMode = 1'b1;
    expectAt(1, 1, 1, "R7 R10 independent both on");
    waitN(3);

    // R9: high-side inhibit
    inhibitHigh = 1'b1;
    expectAt(1, 0, 1, "R9 hi inhibited lo kept");
    expectAt(3, 0, 1, "R9 hi inhibited held");
    waitN(3);
    inhibitHigh = 1'b0;
    expectAt(1, 1, 1, "R10 hi back after inhibit release");
    waitN(3);

    // R8: global inhibit
    inhibitAll = 1'b1;
    expectAt(1, 0, 0, "R8 all inhibited");
    expectAt(3, 0, 0, "R8 all inhibited held");
    waitN(4);
    inhibitAll = 1'b0;
    expectAt(1, 1, 1, "R7 R10 both back in independent mode");
    waitN(3);

    // R7: independent outputs follow levels
    hiCmdN = 1'b1;
    expectAt(L - 1, 1, 1, "R7 hi still on");
    expectAt(L,     0, 1, "R7 hi follows input off");
    waitN(L + 3);

    // R10/R8/R5: back to complementary; inhibit then release waits deadtime
    indepMode = 1'b0;
    expectAt(1, 0, 1, "R10 complementary lo kept");
    waitN(2);
    inhibitAll = 1'b1;
    m = 0;
    expectAt(1,     0, 0, "R8 lo inhibited");
    expectAt(D,     0, 0, "R5 lo held after inhibit release");
    expectAt(D + 1, 0, 1, "R5 lo back after deadtime");
    waitN(4);
    inhibitAll = 1'b0;
    waitN(D + 5);

    // R9: high inhibit leaves low side on in complementary mode
    inhibitHigh = 1'b1;
    expectAt(1, 0, 1, "R9 lo unaffected");
    expectAt(4, 0, 1, "R9 lo unaffected held");
    waitN(5);
    inhibitHigh = 1'b0;
    expectAt(2, 0, 1, "R9 lo still on after release");
    waitN(4 + m);

    while (expQ.size() != 0) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule